// File: doc/BRIEF.md
# EDO DRAM Access Controller

This block sits between a simple host request port and a 4M x 16 EDO DRAM with a multiplexed address bus. Each host request carries a 22-bit word address, a write flag, two byte enables and 16 bits of write data. The block splits the address into a 13-bit row and a 9-bit column, and drives the row, then the column, onto a shared 13-bit bus. It produces the row strobe, one column strobe per byte lane, the write strobe and the output enable. Read data is captured from the DRAM data bus and returned with a one-cycle valid pulse.

After an access the row stays open. A later request to the same row needs only a new column cycle (hyper page mode). A request to another row first precharges the array. A timer inserts a CAS-before-RAS refresh at a fixed interval, and that refresh takes priority over host traffic. Every timing value is a whole number of clock cycles, taken from parameters whose defaults live in the package.

Top module: `edo_dram_ctrl`

## Requirements
- R1: While reset is held, and in idle after it, RAS, both CAS lines, WE and OE are high (inactive) and rdValid is low.
- R2: The bus carries the row (address bits 21:9) from before RAS falls until the column setup cycle. It carries the column (address bits 8:0, zero-extended) from the column setup cycle while the row is open. The bus does not change in the cycle in which RAS falls.
- R3: Byte enable bit 0 selects the lower CAS (data bits 7:0) and bit 1 selects the upper CAS (data bits 15:8). Enable 2'b11 lowers both, and 2'b00 lowers neither.
- R4: A write holds WE low, OE high and the write data driven during the column setup cycle and the CAS-low cycles, so WE falls before CAS (early write). A read holds WE high and OE low in the same cycles. WE and OE are high at all other times.
- R5: A read samples the data bus at the end of its last CAS-low cycle. The value appears on rdData with rdValid high for exactly one cycle, the cycle after CAS rises. Enabled lanes return the data last written there.
- R6: A request accepted while a row is open and addressing that row keeps RAS low. It starts its column setup cycle in the very next cycle.
- R7: A request to a different row raises RAS for T_RP cycles with the new row on the bus. RAS then falls directly, with no separate row setup cycle.
- R8: A request accepted from idle spends one cycle with the row on the bus and RAS high, then T_RCD cycles with RAS low, then one column setup cycle. CAS then stays low for T_CAS cycles, followed by T_CP cycles with CAS high before the row counts as open.
- R9: A refresh lowers both CAS lines with RAS high and WE high for T_CSR cycles. It then lowers RAS for T_RFC cycles with CAS still low, then holds everything high for T_RP cycles.
- R10: A refresh becomes due every T_REFI cycles. While it is due, no host request is accepted. An open row is first closed with T_RP cycles of RAS high, and a row change already accepted finishes its precharge before the refresh.
- R11: reqReady is high only in idle or with a row open and its column precharge done, and only while no refresh is due.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Controller takes the request this cycle |
| reqAddr | input | 22 | Word address, row in bits 21:9 |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqByteEn | input | 2 | Lane enables, bit 0 lower byte |
| reqWdata | input | 16 | Write data |
| rdValid | output | 1 | One-cycle read data valid |
| rdData | output | 16 | Read data |
| dramAddr | output | 13 | Multiplexed row/column bus |
| dramRasN | output | 1 | Row strobe, active low |
| dramCasLN | output | 1 | Lower-lane column strobe, active low |
| dramCasUN | output | 1 | Upper-lane column strobe, active low |
| dramWeN | output | 1 | Write strobe, active low |
| dramOeN | output | 1 | Output enable, active low |
| dramDqOut | output | 16 | Data toward the DRAM |
| dramDqOe | output | 1 | Enable for the data driver |
| dramDqIn | input | 16 | Data from the DRAM |

## Verification
All strobes and the bus are decoded from registered state. Each of them therefore changes in the cycle that follows the edge where the controller decides: the accepting edge, the edge where a phase count expires, or the edge where a refresh becomes due. The one exception is rdValid, which rises one cycle after the final CAS-low cycle. The refresh becomes due T_REFI edges after reset or after the previous one.

A behavioural timeline in the bench advances one step per clock and tracks its own refresh count. It sets the expected pin values for each cycle just after the rising edge. It compares them with the design at the following falling edge, so every result is sampled in the cycle where it is due and never at an edge.

// File: rtl/edo_ctrl_pkg.sv
package edo_ctrl_pkg;

  // geometry defaults
  localparam int DEF_ROW_W  = 13;
  localparam int DEF_COL_W  = 9;
  localparam int DEF_DATA_W = 16;

  // timing defaults in cycles of a 20 ns clock (50 ns grade)
  localparam int DEF_T_RCD  = 2;    // RAS low before the column setup cycle
  localparam int DEF_T_CAS  = 1;    // CAS low width
  localparam int DEF_T_CP   = 1;    // CAS high between page accesses
  localparam int DEF_T_RP   = 2;    // RAS precharge
  localparam int DEF_T_CSR  = 1;    // CAS low before RAS in refresh
  localparam int DEF_T_RFC  = 3;    // RAS low during refresh
  localparam int DEF_T_REFI = 780;  // refresh interval, ~15.6 us

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  typedef enum logic [3:0] {
    PH_IDLE, PH_ROW, PH_RCD, PH_COL, PH_CAS, PH_CP,
    PH_OPEN, PH_PRE, PH_REFC, PH_REFR, PH_REFP
  } phase_e;

  typedef struct packed {
    logic rasLow;    // row strobe active
    logic colAddr;   // column on the bus
    logic opActive;  // WE/OE/data driver follow the request
    logic casAcc;    // lane strobes follow byte enables
    logic casAll;    // both lane strobes low (refresh)
    logic latchReq;  // capture host request
    logic sampleRd;  // capture read data
  } strobe_t;

endpackage

// File: rtl/edo_ctrl_fsm.sv
module edo_ctrl_fsm
  import edo_ctrl_pkg::*;
#(
  parameter int T_RCD  = DEF_T_RCD,
  parameter int T_CAS  = DEF_T_CAS,
  parameter int T_CP   = DEF_T_CP,
  parameter int T_RP   = DEF_T_RP,
  parameter int T_CSR  = DEF_T_CSR,
  parameter int T_RFC  = DEF_T_RFC,
  parameter int T_REFI = DEF_T_REFI
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    rowHit,
  output logic    reqReady,
  output strobe_t strb
);

  localparam int T_MAX = maxInt(maxInt(maxInt(T_RCD, T_CAS), maxInt(T_CP, T_RP)),
                                maxInt(T_CSR, T_RFC));
  localparam int CNT_W = $clog2(T_MAX + 1);
  localparam int REF_W = $clog2(T_REFI);

  phase_e           state, nx;
  logic [CNT_W-1:0] cnt, ld;
  logic [REF_W-1:0] refCnt;
  logic             refPend, refFire, enterRef;
  logic             pend, setPend, clrPend;
  logic             cntDone, accept;

  assign cntDone  = (cnt == '0);
  assign refFire  = (refCnt == REF_W'(T_REFI - 1));
  assign reqReady = ((state == PH_IDLE) || (state == PH_OPEN)) && !refPend;
  assign accept   = reqValid && reqReady;

  always_comb begin
    nx       = state;
    ld       = '0;
    setPend  = 1'b0;
    clrPend  = 1'b0;
    enterRef = 1'b0;
    unique case (state)
      PH_IDLE:
        if (refPend) begin
          nx = PH_REFC; ld = CNT_W'(T_CSR - 1); enterRef = 1'b1;
        end else if (accept) begin
          nx = PH_ROW;
        end
      PH_ROW: begin nx = PH_RCD; ld = CNT_W'(T_RCD - 1); end
      PH_RCD: if (cntDone) nx = PH_COL;
      PH_COL: begin nx = PH_CAS; ld = CNT_W'(T_CAS - 1); end
      PH_CAS: if (cntDone) begin nx = PH_CP; ld = CNT_W'(T_CP - 1); end
      PH_CP:  if (cntDone) nx = PH_OPEN;
      PH_OPEN:
        if (refPend) begin
          nx = PH_PRE; ld = CNT_W'(T_RP - 1);
        end else if (accept) begin
          if (rowHit) nx = PH_COL;
          else begin nx = PH_PRE; ld = CNT_W'(T_RP - 1); setPend = 1'b1; end
        end
      PH_PRE:
        if (cntDone) begin
          if (refPend) begin
            nx = PH_REFC; ld = CNT_W'(T_CSR - 1); enterRef = 1'b1;
          end else if (pend) begin
            nx = PH_RCD; ld = CNT_W'(T_RCD - 1); clrPend = 1'b1;
          end else begin
            nx = PH_IDLE;
          end
        end
      PH_REFC: if (cntDone) begin nx = PH_REFR; ld = CNT_W'(T_RFC - 1); end
      PH_REFR: if (cntDone) begin nx = PH_REFP; ld = CNT_W'(T_RP - 1); end
      PH_REFP:
        if (cntDone) begin
          if (pend) begin nx = PH_RCD; ld = CNT_W'(T_RCD - 1); clrPend = 1'b1; end
          else nx = PH_IDLE;
        end
      default: nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= PH_IDLE;
      cnt     <= '0;
      refCnt  <= '0;
      refPend <= 1'b0;
      pend    <= 1'b0;
    end else begin
      state   <= nx;
      cnt     <= (nx != state) ? ld : (cntDone ? '0 : cnt - 1'b1);
      refCnt  <= refFire ? '0 : refCnt + 1'b1;
      refPend <= refFire | (refPend & ~enterRef);
      pend    <= setPend | (pend & ~clrPend);
    end
  end

  always_comb begin
    strb.rasLow   = (state == PH_RCD) || (state == PH_COL) || (state == PH_CAS) ||
                    (state == PH_CP)  || (state == PH_OPEN) || (state == PH_REFR);
    strb.colAddr  = (state == PH_COL) || (state == PH_CAS) || (state == PH_CP) ||
                    (state == PH_OPEN);
    strb.opActive = (state == PH_COL) || (state == PH_CAS);
    strb.casAcc   = (state == PH_CAS);
    strb.casAll   = (state == PH_REFC) || (state == PH_REFR);
    strb.latchReq = accept;
    strb.sampleRd = (state == PH_CAS) && cntDone;
  end

endmodule

// File: rtl/edo_ctrl_dp.sv
module edo_ctrl_dp
  import edo_ctrl_pkg::*;
#(
  parameter int ROW_W  = DEF_ROW_W,
  parameter int COL_W  = DEF_COL_W,
  parameter int DATA_W = DEF_DATA_W,
  parameter int LANES  = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  strb,
  input  logic [ROW_W+COL_W-1:0]   reqAddr,
  input  logic                     reqWrite,
  input  logic [LANES-1:0]         reqByteEn,
  input  logic [DATA_W-1:0]        reqWdata,
  input  logic [DATA_W-1:0]        dramDqIn,
  output logic                     rowHit,
  output logic [maxInt(ROW_W, COL_W)-1:0] dramAddr,
  output logic                     dramRasN,
  output logic [LANES-1:0]         dramCasN,
  output logic                     dramWeN,
  output logic                     dramOeN,
  output logic [DATA_W-1:0]        dramDqOut,
  output logic                     dramDqOe,
  output logic                     rdValid,
  output logic [DATA_W-1:0]        rdData
);

  localparam int AW    = ROW_W + COL_W;
  localparam int BUS_W = maxInt(ROW_W, COL_W);

  logic [ROW_W-1:0]  rowQ;
  logic [COL_W-1:0]  colQ;
  logic              weQ;
  logic [LANES-1:0]  beQ;
  logic [DATA_W-1:0] wdQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowQ <= '0; colQ <= '0; weQ <= 1'b0; beQ <= '0; wdQ <= '0;
      rdValid <= 1'b0; rdData <= '0;
    end else begin
      if (strb.latchReq) begin
        rowQ <= reqAddr[AW-1:COL_W];
        colQ <= reqAddr[COL_W-1:0];
        weQ  <= reqWrite;
        beQ  <= reqByteEn;
        wdQ  <= reqWdata;
      end
      rdValid <= strb.sampleRd && !weQ;
      if (strb.sampleRd && !weQ) rdData <= dramDqIn;
    end
  end

  assign rowHit    = (reqAddr[AW-1:COL_W] == rowQ);
  assign dramAddr  = strb.colAddr ? BUS_W'(colQ) : BUS_W'(rowQ);
  assign dramRasN  = ~strb.rasLow;
  assign dramWeN   = ~(strb.opActive & weQ);
  assign dramOeN   = ~(strb.opActive & ~weQ);
  assign dramDqOe  = strb.opActive & weQ;
  assign dramDqOut = wdQ;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dramCasN[g] = ~(strb.casAll | (strb.casAcc & beQ[g]));
  end

endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl
  import edo_ctrl_pkg::*;
#(
  parameter int ROW_W  = DEF_ROW_W,
  parameter int COL_W  = DEF_COL_W,
  parameter int DATA_W = DEF_DATA_W,
  parameter int T_RCD  = DEF_T_RCD,
  parameter int T_CAS  = DEF_T_CAS,
  parameter int T_CP   = DEF_T_CP,
  parameter int T_RP   = DEF_T_RP,
  parameter int T_CSR  = DEF_T_CSR,
  parameter int T_RFC  = DEF_T_RFC,
  parameter int T_REFI = DEF_T_REFI
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             reqValid,
  output logic                             reqReady,
  input  logic [ROW_W+COL_W-1:0]           reqAddr,
  input  logic                             reqWrite,
  input  logic [1:0]                       reqByteEn,
  input  logic [DATA_W-1:0]                reqWdata,
  output logic                             rdValid,
  output logic [DATA_W-1:0]                rdData,
  output logic [maxInt(ROW_W, COL_W)-1:0]  dramAddr,
  output logic                             dramRasN,
  output logic                             dramCasLN,
  output logic                             dramCasUN,
  output logic                             dramWeN,
  output logic                             dramOeN,
  output logic [DATA_W-1:0]                dramDqOut,
  output logic                             dramDqOe,
  input  logic [DATA_W-1:0]                dramDqIn
);

  localparam int LANES = 2;

  strobe_t          strb;
  logic             rowHit;
  logic [LANES-1:0] casN;

  edo_ctrl_fsm #(
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP),
    .T_CSR(T_CSR), .T_RFC(T_RFC), .T_REFI(T_REFI)
  ) u_fsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .rowHit(rowHit),
    .reqReady(reqReady), .strb(strb)
  );

  edo_ctrl_dp #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .LANES(LANES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqByteEn(reqByteEn),
    .reqWdata(reqWdata), .dramDqIn(dramDqIn), .rowHit(rowHit),
    .dramAddr(dramAddr), .dramRasN(dramRasN), .dramCasN(casN),
    .dramWeN(dramWeN), .dramOeN(dramOeN), .dramDqOut(dramDqOut),
    .dramDqOe(dramDqOe), .rdValid(rdValid), .rdData(rdData)
  );

  assign dramCasLN = casN[0];
  assign dramCasUN = casN[1];

endmodule

// File: rtl/edo_dram_ctrl_chk.sv
module edo_dram_ctrl_chk #(
  parameter int BUS_W = 13
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqReady,
  input logic             rdValid,
  input logic [BUS_W-1:0] dramAddr,
  input logic             dramRasN,
  input logic             dramCasLN,
  input logic             dramCasUN,
  input logic             dramWeN,
  input logic             dramOeN,
  input logic             dramDqOe
);

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (dramRasN && dramCasLN && dramCasUN && dramWeN && dramOeN && !rdValid)); // R1

  AST_ROW_BUS_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dramRasN) |-> $stable(dramAddr)); // R2

  AST_WE_IN_ROW: assert property (@(posedge clk) disable iff (!rstN)
    !dramWeN |-> (!dramRasN && dramOeN && dramDqOe)); // R4

  AST_RD_ONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid); // R5

  AST_CBR_WE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (!dramCasLN && !dramCasUN && dramRasN) |-> (dramWeN && dramOeN)); // R9

  AST_READY_NO_CAS: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (dramCasLN && dramCasUN)); // R11

endmodule

bind edo_dram_ctrl edo_dram_ctrl_chk #(.BUS_W(edo_ctrl_pkg::maxInt(ROW_W, COL_W))) u_chk (.*);

// File: tb/edo_dram_ctrl_bench.sv
module edo_dram_ctrl_bench;
  import edo_ctrl_pkg::*;

  localparam int RW = DEF_ROW_W;
  localparam int CW = DEF_COL_W;
  localparam int AW = RW + CW;
  localparam int BW = (RW > CW) ? RW : CW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rstN = 1'b0;
  logic          reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [1:0]    reqByteEn = '0;
  logic [15:0]   reqWdata = '0, dramDqIn = '0;
  logic          reqReady, rdValid, dramRasN, dramCasLN, dramCasUN, dramWeN, dramOeN, dramDqOe;
  logic [15:0]   rdData, dramDqOut;
  logic [BW-1:0] dramAddr;

  edo_dram_ctrl u_edo_dram_ctrl (.*);

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] defVal(input int idx);
    return idx[15:0] ^ 16'h5A3C;
  endfunction

  // host-side golden memory and pin-side DRAM memory
  logic [15:0] gold [int];
  logic [15:0] pmem [int];

  function automatic logic [15:0] goldRd(input int idx);
    return gold.exists(idx) ? gold[idx] : defVal(idx);
  endfunction
  function automatic logic [15:0] pmemRd(input int idx);
    return pmem.exists(idx) ? pmem[idx] : defVal(idx);
  endfunction

  // pin-level DRAM behaviour, evaluated mid-cycle
  logic [RW-1:0] pRow = '0;
  logic [CW-1:0] pCol = '0;
  logic pRas = 1'b1, pCasL = 1'b1, pCasU = 1'b1;
  always @(negedge clk) begin
    logic [15:0] w;
    if (pRas && !dramRasN && dramCasLN && dramCasUN) pRow = dramAddr[RW-1:0];
    if (!dramRasN && ((pCasL && !dramCasLN) || (pCasU && !dramCasUN))) begin
      pCol = dramAddr[CW-1:0];
      if (!dramWeN) begin
        w = pmemRd({pRow, pCol});
        if (!dramCasLN) w[7:0]  = dramDqOut[7:0];
        if (!dramCasUN) w[15:8] = dramDqOut[15:8];
        pmem[{pRow, pCol}] = w;
      end
    end
    w = pmemRd({pRow, pCol});
    dramDqIn = {(!dramCasUN && !dramOeN) ? w[15:8] : 8'h00,
                (!dramCasLN && !dramOeN) ? w[7:0]  : 8'h00};
    pRas = dramRasN; pCasL = dramCasLN; pCasU = dramCasUN;
  end

  // expected values for the current cycle
  logic eRas, eCasL, eCasU, eWe, eOe, eDqOe, eReady, eRdv, modelOn = 1'b0;
  logic [BW-1:0] eAddr;
  logic [15:0]   eRdData, eDqOut;
  string         eTag = "R1";

  // model state
  logic [RW-1:0] mRow = '0;
  logic [CW-1:0] mCol = '0;
  logic          mWe = 1'b0;
  logic [1:0]    mBe = '0;
  logic [15:0]   mWd = '0, rdArmData = '0;
  logic          rdvArm = 1'b0, refDue = 1'b0;
  int            refCnt = 0;

  function automatic logic [BW-1:0] rowBus();
    return BW'(mRow);
  endfunction
  function automatic logic [BW-1:0] colBus();
    return BW'(mCol);
  endfunction

  task automatic cyc(input logic ras, input logic cl, input logic cu, input logic we,
                     input logic oe, input logic dqoe, input logic rdy,
                     input logic [BW-1:0] ad, input logic clr, input string tag,
                     output logic fired);
    eRas = ras; eCasL = cl; eCasU = cu; eWe = we; eOe = oe; eDqOe = dqoe;
    eReady = rdy; eAddr = ad; eTag = tag; eDqOut = mWd;
    eRdv = rdvArm; eRdData = rdArmData; rdvArm = 1'b0;
    modelOn = 1'b1;
    @(posedge clk);
    fired = rdy && reqValid;
    if (clr) refDue = 1'b0;
    refCnt++;
    if (refCnt == DEF_T_REFI) begin refCnt = 0; refDue = 1'b1; end
  endtask

  task automatic take();
    logic [15:0] g;
    mRow = reqAddr[AW-1:CW]; mCol = reqAddr[CW-1:0];
    mWe = reqWrite; mBe = reqByteEn; mWd = reqWdata;
    g = goldRd(int'(reqAddr));
    if (mWe) begin
      if (mBe[0]) g[7:0]  = mWd[7:0];
      if (mBe[1]) g[15:8] = mWd[15:8];
      gold[int'(reqAddr)] = g;
    end else begin
      rdArmData = {mBe[1] ? g[15:8] : 8'h00, mBe[0] ? g[7:0] : 8'h00};
    end
  endtask

  // R8: column setup, CAS low, CAS precharge
  task automatic access();
    logic f;
    cyc(0, 1, 1, !mWe, mWe, mWe, 0, colBus(), 0, "R8", f);
    for (int i = 0; i < DEF_T_CAS; i++)
      cyc(0, !mBe[0], !mBe[1], !mWe, mWe, mWe, 0, colBus(), 0, "R8", f);
    if (!mWe) rdvArm = 1'b1;
    for (int i = 0; i < DEF_T_CP; i++)
      cyc(0, 1, 1, 1, 1, 0, 0, colBus(), 0, "R8", f);
  endtask

  task automatic rcd();
    logic f;
    for (int i = 0; i < DEF_T_RCD; i++) cyc(0, 1, 1, 1, 1, 0, 0, rowBus(), 0, "R8", f);
  endtask

  // R9: CAS-before-RAS refresh
  task automatic refresh();
    logic f;
    for (int i = 0; i < DEF_T_CSR; i++) cyc(1, 0, 0, 1, 1, 0, 0, rowBus(), 0, "R9", f);
    for (int i = 0; i < DEF_T_RFC; i++) cyc(0, 0, 0, 1, 1, 0, 0, rowBus(), 0, "R9", f);
    for (int i = 0; i < DEF_T_RP;  i++) cyc(1, 1, 1, 1, 1, 0, 0, rowBus(), 0, "R9", f);
  endtask

  // precharge; reports whether a refresh follows (R7 / R10)
  task automatic pre(input string tag, output logic goRef);
    logic f, d;
    goRef = 1'b0;
    for (int i = 0; i < DEF_T_RP; i++) begin
      d = (i == DEF_T_RP - 1) && refDue;
      cyc(1, 1, 1, 1, 1, 0, 0, rowBus(), d, tag, f);
      if (d) goRef = 1'b1;
    end
  endtask

  initial begin : model
    logic open, f, due, goRef;
    logic [RW-1:0] oldRow;
    open = 1'b0;
    wait (rstN === 1'b1);
    forever begin
      if (!open) begin
        due = refDue;
        cyc(1, 1, 1, 1, 1, 0, !due, rowBus(), due, "R1", f);
        if (due) refresh();
        else if (f) begin
          take();
          cyc(1, 1, 1, 1, 1, 0, 0, rowBus(), 0, "R8", f);
          rcd(); access(); open = 1'b1;
        end
      end else begin
        due = refDue;
        cyc(0, 1, 1, 1, 1, 0, !due, colBus(), 0, "R6", f);
        if (due) begin
          pre("R10", goRef); refresh(); open = 1'b0;
        end else if (f) begin
          oldRow = mRow;
          take();
          if (mRow == oldRow) access();
          else begin
            pre("R7", goRef);
            if (goRef) refresh();
            rcd(); access();
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (modelOn && rstN && !finished) begin
      chk(eTag,  "rasN",  {31'b0, dramRasN},  {31'b0, eRas});
      chk("R2",  "addr",  32'(dramAddr),      32'(eAddr));
      chk("R3",  "casL",  {31'b0, dramCasLN}, {31'b0, eCasL});
      chk("R3",  "casU",  {31'b0, dramCasUN}, {31'b0, eCasU});
      chk("R4",  "weN",   {31'b0, dramWeN},   {31'b0, eWe});
      chk("R4",  "oeN",   {31'b0, dramOeN},   {31'b0, eOe});
      chk("R4",  "dqOe",  {31'b0, dramDqOe},  {31'b0, eDqOe});
      if (eDqOe) chk("R4", "dqOut", {16'b0, dramDqOut}, {16'b0, eDqOut});
      chk("R11", "ready", {31'b0, reqReady},  {31'b0, eReady});
      chk("R5",  "rdValid", {31'b0, rdValid}, {31'b0, eRdv});
      if (eRdv) chk("R5", "rdData", {16'b0, rdData}, {16'b0, eRdData});
    end
  end

  task automatic hostReq(input logic [AW-1:0] a, input logic w, input logic [1:0] be,
                         input logic [15:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqWrite = w; reqByteEn = be; reqWdata = d;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  function automatic logic [AW-1:0] mk(input int row, input int col);
    return {RW'(row), CW'(col)};
  endfunction

  initial begin : stim
    int seed;
    logic [31:0] rnd;
    repeat (3) @(negedge clk);
    // R1: inactive pins during reset
    chk("R1", "rasN reset", {31'b0, dramRasN}, 32'd1);
    chk("R1", "casN reset", {30'b0, dramCasUN, dramCasLN}, 32'd3);
    chk("R1", "we/oe reset", {30'b0, dramWeN, dramOeN}, 32'd3);
    chk("R1", "rdValid reset", {31'b0, rdValid}, 32'd0);
    @(posedge clk); #1 rstN = 1'b1;

    // R3/R6: word write then byte writes and reads on one row
    hostReq(mk(5, 3), 1, 2'b11, 16'h1234);
    hostReq(mk(5, 3), 0, 2'b11, 16'h0);
    hostReq(mk(5, 3), 1, 2'b01, 16'hFFEE);
    hostReq(mk(5, 3), 0, 2'b11, 16'h0);
    hostReq(mk(5, 3), 1, 2'b10, 16'h77FF);
    hostReq(mk(5, 3), 0, 2'b01, 16'h0);
    hostReq(mk(5, 3), 1, 2'b00, 16'hDEAD);   // R3: no lane written
    hostReq(mk(5, 3), 0, 2'b11, 16'h0);
    // R7: row change and return
    hostReq(mk(8191, 511), 1, 2'b11, 16'hA5A5);
    hostReq(mk(5, 3), 0, 2'b10, 16'h0);
    hostReq(mk(8191, 511), 0, 2'b11, 16'h0);
    // R10: page left open until a refresh closes it, then refresh from idle
    repeat (1700) @(negedge clk);
    hostReq(mk(0, 0), 0, 2'b11, 16'h0);

    // mixed traffic across several rows, crossing refreshes
    seed = 7;
    for (int n = 0; n < 600; n++) begin
      seed = seed * 1103515245 + 12345;
      rnd = 32'(seed);
      hostReq(mk(int'(rnd[17:16]) * 3, int'(rnd[8:0])), rnd[20], rnd[22:21], rnd[15:0]);
      if (rnd[30:28] == 3'd0) repeat (int'(rnd[27:24]) * 20) @(negedge clk);
    end
    repeat (20) @(negedge clk);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule